// File: doc/BRIEF.md
# Eight-Line Interrupting GPIO Controller

This block drives and samples eight general-purpose pins from a simple APB-style register bus with zero wait states. Each line is an input or an output, set by a direction bit. The output enable and the output value leave the block as separate signals, so the pad can be built outside it.

Pin data is reached through a window in which the word address is itself a per-line bit mask. A store changes only the selected lines. A load returns zero in every position that is not selected. Software can therefore update single lines without a read-modify-write sequence.

Every line has its own interrupt detector. It watches the synchronised pin and can trigger on a high or low level, on a rising or falling edge, or on both edges. Edge events are latched until software clears them, while level events follow the pin. Raw and enabled status can both be read, and one combined request line goes to the system interrupt controller.

Top module: `gpio_octet`

## Requirements
- R1: After reset, all configuration state is zero: every line is an input using falling-edge detection, interrupts are disabled, `pinOe` is 0, `irqOut` is 0, and every register reads 0 while the pins are low.
- R2: An access whose byte address has bits [11:10] equal to 0 targets the data window, and address bits [9:2] form the line mask (bit 2 is line 0). A store sets the output data of each masked line to the matching write-data bit and leaves unmasked lines unchanged. A store with an all-zero mask changes nothing.
- R3: A load from the data window returns 0 in unmasked positions. In masked positions it returns the output data for output lines and the synchronised pin value for input lines. Pins pass through a two-flop synchroniser.
- R4: Direction register at 0x400: a 1 makes the line an output. `pinOe` equals the direction bits. `pinOut` is 0 on input lines, and stored data appears on `pinOut` once the line is switched to output.
- R5: The sense register (0x404) selects edge detection when its bit is 0. With the both-edges bit (0x408) set, rising and falling edges both latch status and the polarity bit is ignored. With the both-edges bit clear, polarity (0x40C) 1 selects rising edges and 0 selects falling edges.
- R6: When a sense bit is 1, the line uses level detection. Polarity 1 flags the line while the pin is high, and polarity 0 flags it while the pin is low. This status is not latched and drops when the level goes away.
- R7: Enabled status (0x418) is raw status (0x414) ANDed with the enable register (0x410). `irqOut` is 1 exactly when any enabled status bit is 1.
- R8: Writing 1 to a bit of the clear register (0x41C) clears that line's latched edge status. Bits written as 0 have no effect, and level status is not affected by a clear.
- R9: If a new edge is detected for a line in the same cycle that a clear write for that line is committed, the status bit remains set.
- R10: The configuration registers at 0x400–0x410 read back what was written. Raw and enabled status ignore writes. The clear register and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Peripheral select |
| busEnable | input | 1 | Access phase strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid during the access phase |
| pinIn | input | 8 | Asynchronous pin inputs |
| pinOut | output | 8 | Output value per line |
| pinOe | output | 8 | Output enable per line |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The masked data window is driven with a table of mask, data and read-mask patterns. The patterns cover full, empty, single-bit and split masks, so the bench can tell a correct masked merge apart from a plain overwrite or an ignored mask.

The interrupt detectors are driven with one configuration that gives each line a different mode: rising, falling, both edges, level high and level low. The pins are then moved through patterns that make some lines trigger and leave others quiet. This separates the latched edge status from the level status that follows the pin. A clear is also committed in the same cycle as a fresh edge, which checks which of the two wins.

// File: rtl/gpio_octet_pkg.sv
package gpio_octet_pkg;
  parameter int GPIO_LINES = 8;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH, RD_POL, RD_IE, RD_RAW, RD_MASKED
  } rdSel_t;

  typedef struct packed {
    logic                  wrData;
    logic                  wrDir;
    logic                  wrSense;
    logic                  wrBoth;
    logic                  wrPol;
    logic                  wrIe;
    logic                  wrClr;
    logic [GPIO_LINES-1:0] mask;
    rdSel_t                rdSel;
  } regStrobe_t;
endpackage

// File: rtl/gpio_octet_ctrl.sv
module gpio_octet_ctrl
  import gpio_octet_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  localparam int MASK_LSB = 2;
  localparam int MASK_MSB = MASK_LSB + GPIO_LINES - 1;
  localparam int WIN_LSB  = MASK_MSB + 1;
  localparam int IDX_MSB  = MASK_LSB + 2;

  logic       access;
  logic       inData;
  logic       inCfg;
  logic [2:0] regIdx;

  assign access = busSel && busEnable;
  assign inData = (busAddr[ADDR_W-1:WIN_LSB] == '0) && (busAddr[1:0] == 2'b00);
  assign inCfg  = (busAddr[ADDR_W-1:WIN_LSB] == (ADDR_W-WIN_LSB)'(1)) &&
                  (busAddr[MASK_MSB:IDX_MSB+1] == '0) && (busAddr[1:0] == 2'b00);
  assign regIdx = busAddr[IDX_MSB:MASK_LSB];

  always_comb begin
    strobe.wrData  = 1'b0;
    strobe.wrDir   = 1'b0;
    strobe.wrSense = 1'b0;
    strobe.wrBoth  = 1'b0;
    strobe.wrPol   = 1'b0;
    strobe.wrIe    = 1'b0;
    strobe.wrClr   = 1'b0;
    strobe.mask    = busAddr[MASK_MSB:MASK_LSB];
    strobe.rdSel   = RD_NONE;
    if (access) begin
      if (inData) begin
        strobe.wrData = busWrite;
        strobe.rdSel  = RD_DATA;
      end else if (inCfg) begin
        case (regIdx)
          3'd0: begin strobe.wrDir   = busWrite; strobe.rdSel = RD_DIR;   end
          3'd1: begin strobe.wrSense = busWrite; strobe.rdSel = RD_SENSE; end
          3'd2: begin strobe.wrBoth  = busWrite; strobe.rdSel = RD_BOTH;  end
          3'd3: begin strobe.wrPol   = busWrite; strobe.rdSel = RD_POL;   end
          3'd4: begin strobe.wrIe    = busWrite; strobe.rdSel = RD_IE;    end
          3'd5: strobe.rdSel = RD_RAW;
          3'd6: strobe.rdSel = RD_MASKED;
          default: strobe.wrClr = busWrite;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_octet_dpath.sv
module gpio_octet_dpath
  import gpio_octet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [GPIO_LINES-1:0] busWdata,
  output logic [GPIO_LINES-1:0] busRdata,
  input  logic [GPIO_LINES-1:0] pinIn,
  output logic [GPIO_LINES-1:0] pinOut,
  output logic [GPIO_LINES-1:0] pinOe,
  output logic                  irqOut,
  output logic [GPIO_LINES-1:0] rawStat,
  output logic [GPIO_LINES-1:0] ieVal
);
  localparam int N = GPIO_LINES;

  logic [N-1:0] dataReg, dirReg, senseReg, bothReg, polReg, ieReg, edgeStat;
  logic [SYNC_STAGES-1:0][N-1:0] syncQ;
  logic [N-1:0] syncIn, prevIn;
  logic [N-1:0] edgeHit, levelHit, maskedStat, clrBits;

  // pin synchroniser followed by one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      prevIn <= '0;
    end else begin
      syncQ[0] <= pinIn;
      prevIn   <= syncQ[SYNC_STAGES-1];
    end
  end

  generate
    for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else       syncQ[s] <= syncQ[s-1];
      end
    end
  endgenerate

  assign syncIn = syncQ[SYNC_STAGES-1];

  // per-line trigger decode
  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      logic rise, fall;
      assign rise        = syncIn[i] & ~prevIn[i];
      assign fall        = ~syncIn[i] & prevIn[i];
      assign edgeHit[i]  = ~senseReg[i] &
                           (bothReg[i] ? (rise | fall) : (polReg[i] ? rise : fall));
      assign levelHit[i] = senseReg[i] & (polReg[i] ? syncIn[i] : ~syncIn[i]);
    end
  endgenerate

  assign clrBits = strobe.wrClr ? busWdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      dirReg   <= '0;
      senseReg <= '0;
      bothReg  <= '0;
      polReg   <= '0;
      ieReg    <= '0;
      edgeStat <= '0;
    end else begin
      if (strobe.wrData)  dataReg  <= (dataReg & ~strobe.mask) | (busWdata & strobe.mask);
      if (strobe.wrDir)   dirReg   <= busWdata;
      if (strobe.wrSense) senseReg <= busWdata;
      if (strobe.wrBoth)  bothReg  <= busWdata;
      if (strobe.wrPol)   polReg   <= busWdata;
      if (strobe.wrIe)    ieReg    <= busWdata;
      edgeStat <= (edgeStat & ~clrBits) | edgeHit;
    end
  end

  assign rawStat    = (edgeStat & ~senseReg) | levelHit;
  assign maskedStat = rawStat & ieReg;
  assign irqOut     = |maskedStat;
  assign ieVal      = ieReg;
  assign pinOe      = dirReg;
  assign pinOut     = dataReg & dirReg;

  always_comb begin
    case (strobe.rdSel)
      RD_DATA:   busRdata = ((dirReg & dataReg) | (~dirReg & syncIn)) & strobe.mask;
      RD_DIR:    busRdata = dirReg;
      RD_SENSE:  busRdata = senseReg;
      RD_BOTH:   busRdata = bothReg;
      RD_POL:    busRdata = polReg;
      RD_IE:     busRdata = ieReg;
      RD_RAW:    busRdata = rawStat;
      RD_MASKED: busRdata = maskedStat;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_octet.sv
module gpio_octet
  import gpio_octet_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busEnable,
  input  logic                  busWrite,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [GPIO_LINES-1:0] busWdata,
  output logic [GPIO_LINES-1:0] busRdata,
  input  logic [GPIO_LINES-1:0] pinIn,
  output logic [GPIO_LINES-1:0] pinOut,
  output logic [GPIO_LINES-1:0] pinOe,
  output logic                  irqOut
);
  regStrobe_t            strobe;
  logic [GPIO_LINES-1:0] rawStat;
  logic [GPIO_LINES-1:0] ieVal;

  gpio_octet_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel(busSel), .busEnable(busEnable), .busWrite(busWrite),
    .busAddr(busAddr), .strobe(strobe)
  );

  gpio_octet_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqOut(irqOut), .rawStat(rawStat), .ieVal(ieVal)
  );
endmodule

// File: rtl/gpio_octet_chk.sv
module gpio_octet_chk
  import gpio_octet_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busSel,
  input logic                  busEnable,
  input logic                  busWrite,
  input logic [ADDR_W-1:0]     busAddr,
  input logic [GPIO_LINES-1:0] busWdata,
  input logic [GPIO_LINES-1:0] pinOut,
  input logic [GPIO_LINES-1:0] pinOe,
  input logic                  irqOut,
  input logic [GPIO_LINES-1:0] rawStat,
  input logic [GPIO_LINES-1:0] ieVal
);
  localparam int WIN_LSB = GPIO_LINES + 2;
  localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << WIN_LSB;

  logic wrAcc, zeroMaskWr;
  assign wrAcc      = busSel && busEnable && busWrite;
  assign zeroMaskWr = wrAcc && (busAddr[ADDR_W-1:WIN_LSB] == '0) &&
                      (busAddr[WIN_LSB-1:2] == '0);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (ieVal == '0 && pinOe == '0 && !irqOut));

  // R4
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAcc && busAddr == DIR_ADDR) |=> (pinOe == $past(busWdata)));

  // R4
  out_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pinOut & ~pinOe) == '0);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (ieVal != '0 && rawStat != '0));

  // R2
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    zeroMaskWr |=> $stable(pinOut));
endmodule

bind gpio_octet gpio_octet_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
  .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
  .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut),
  .rawStat(rawStat), .ieVal(ieVal)
);

// File: tb/tb_gpio_octet.sv
module tb_gpio_octet;
  localparam int PERIOD = 10;
  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
                          A_POL = 12'h40C, A_IE = 12'h410, A_RAW = 12'h414,
                          A_MASKED = 12'h418, A_CLR = 12'h41C;
  localparam int NVEC = 8;
  // each entry: {write mask, write data, read mask}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'hFF, 8'hA5, 8'hFF}, {8'h0F, 8'h00, 8'hFF}, {8'hF0, 8'hFF, 8'hFF},
    {8'h01, 8'hFE, 8'hFF}, {8'h80, 8'h80, 8'h80}, {8'h00, 8'hFF, 8'hFF},
    {8'h3C, 8'h55, 8'hC3}, {8'hFF, 8'h00, 8'hFF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busEnable = 1'b0, busWrite = 1'b0;
  logic [11:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata, pinIn = '0, pinOut, pinOe;
  logic irqOut;
  int checks = 0;
  int fails = 0;
  logic [7:0] model, rd;

  always #(PERIOD/2) clk = ~clk;

  gpio_octet dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .irqOut(irqOut)
  );

  function automatic logic [11:0] dataAddr(input logic [7:0] m);
    return {2'b00, m, 2'b00};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busEnable = 1'b0;
    @(negedge clk);
    busEnable = 1'b1;
    @(negedge clk);
    busSel = 1'b0; busEnable = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; busEnable = 1'b0;
    @(negedge clk);
    busEnable = 1'b1;
    #(PERIOD/4);
    d = busRdata;
    @(negedge clk);
    busSel = 1'b0; busEnable = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 pinOe", pinOe, 8'h00);
    check("R1 irqOut", {7'b0, irqOut}, 8'h00);
    busRd(A_DIR, rd);        check("R1 dir", rd, 8'h00);
    busRd(A_IE, rd);         check("R1 ie", rd, 8'h00);
    busRd(A_RAW, rd);        check("R1 raw", rd, 8'h00);
    busRd(dataAddr(8'hFF), rd); check("R1 data", rd, 8'h00);

    // R4 output gating by direction
    busWr(dataAddr(8'hFF), 8'hFF);
    check("R4 pinOut while input", pinOut, 8'h00);
    busWr(A_DIR, 8'hFF);
    check("R4 pinOe", pinOe, 8'hFF);
    check("R4 pinOut after dir", pinOut, 8'hFF);
    model = 8'hFF;

    // R2 R3 masked data window vectors
    for (int v = 0; v < NVEC; v++) begin
      busWr(dataAddr(VEC[v][23:16]), VEC[v][15:8]);
      model = (model & ~VEC[v][23:16]) | (VEC[v][15:8] & VEC[v][23:16]);
      check("R2 pinOut", pinOut, model);
      busRd(dataAddr(VEC[v][7:0]), rd);
      check("R3 masked read", rd, model & VEC[v][7:0]);
    end

    // R3 input lines read the pins
    busWr(A_DIR, 8'h0F);
    pinIn = 8'hA0;
    settle();
    busRd(dataAddr(8'hFF), rd);  check("R3 input read", rd, (model & 8'h0F) | 8'hA0);
    busRd(dataAddr(8'h30), rd);  check("R3 input masked", rd, 8'h20);
    pinIn = 8'h00;
    busWr(A_DIR, 8'h00);
    settle();

    // R10 config readback
    busWr(A_SENSE, 8'h18);
    busWr(A_BOTH, 8'h04);
    busWr(A_POL, 8'h09);
    busRd(A_SENSE, rd); check("R10 sense", rd, 8'h18);
    busRd(A_BOTH, rd);  check("R10 both", rd, 8'h04);
    busRd(A_POL, rd);   check("R10 pol", rd, 8'h09);
    busRd(A_CLR, rd);   check("R10 clr reads 0", rd, 8'h00);
    busWr(A_CLR, 8'hFF);
    busWr(A_IE, 8'hFF);

    // R6 level low on line 4 with pins low
    busRd(A_RAW, rd);    check("R6 level low", rd, 8'h10);
    busRd(A_MASKED, rd); check("R7 masked", rd, 8'h10);
    check("R7 irq on", {7'b0, irqOut}, 8'h01);
    busWr(A_IE, 8'h00);
    check("R7 irq off", {7'b0, irqOut}, 8'h00);
    busRd(A_MASKED, rd); check("R7 masked off", rd, 8'h00);
    busWr(A_RAW, 8'hFF);
    busRd(A_RAW, rd);    check("R10 raw ignores write", rd, 8'h10);

    // R5 R6 rising edges and level high
    pinIn = 8'h0F;
    settle();
    busRd(A_RAW, rd);    check("R5 rise/both/level", rd, 8'h1D);

    // R5 R6 falling edges, level drops
    pinIn = 8'h10;
    settle();
    busRd(A_RAW, rd);    check("R5 fall/latched", rd, 8'h07);

    // R8 clear edge status
    busWr(A_CLR, 8'h05);
    busRd(A_RAW, rd);    check("R8 clear", rd, 8'h02);
    busWr(A_IE, 8'h01);
    check("R7 irq masked", {7'b0, irqOut}, 8'h00);
    busWr(A_IE, 8'h02);
    check("R7 irq enabled", {7'b0, irqOut}, 8'h01);
    busRd(A_MASKED, rd); check("R7 masked one", rd, 8'h02);

    // R8 clear does not touch level status
    pinIn = 8'h00;
    settle();
    busRd(A_RAW, rd);    check("R6 level returns", rd, 8'h12);
    busWr(A_CLR, 8'h10);
    busRd(A_RAW, rd);    check("R8 level not cleared", rd, 8'h12);
    busWr(A_CLR, 8'h02);
    busRd(A_RAW, rd);    check("R8 edge cleared", rd, 8'h10);

    // R5 rising edge ignored on falling-only line
    pinIn = 8'h02;
    settle();
    busRd(A_RAW, rd);    check("R5 wrong edge ignored", rd, 8'h10);

    // R9 edge and clear in the same cycle
    @(negedge clk);
    pinIn = 8'h00;
    busWr(A_CLR, 8'h02);
    busRd(A_RAW, rd);    check("R9 edge wins over clear", rd, 8'h12);
    busWr(A_CLR, 8'h02);
    busRd(A_RAW, rd);    check("R8 later clear", rd, 8'h10);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule